// File: doc/BRIEF.md
# Byte FIFO Pair with Watermarks

This block holds the two data queues that sit between a host register interface and the bit engine of a byte-oriented serial bus controller. The host pushes 10-bit words (a data byte plus two bus-control flag bits that the engine interprets) into the transmit queue. The engine pops them from the other end. In the other direction the engine pushes received bytes and the host pops them one per read strobe. Both queues present their head entry without a read latency, so the word at the head is valid whenever the queue is not empty.

For the host register decode, the block reports occupancy in zero-based form, a four-bit status nibble and three interrupt causes. Each cause is given both as a level and as a single-cycle pulse on its rising edge. The receive cause fires at a programmable zero-based threshold. The transmit side reports empty and half-empty. A flush control holds the transmit queue empty for as long as it is asserted.

Top module: `sbus_byte_fifos`

## Requirements
- R1: After reset both queues are empty, both occupancy outputs read 0, the status nibble reads 4'b1100, the transmit-empty and transmit-half-empty levels are high, the receive-level cause is low, and no cause pulse is high.
- R2: Each queue delivers its entries in the order in which they were accepted. The head word is visible on `eng_tx_data` and `host_rd_data` while the queue is not empty.
- R3: Each occupancy output equals the entry count minus one. It reads 0 when the queue is empty and DEPTH-1 (15) when the queue is full.
- R4: At DEPTH entries the transmit-full status bit is set. A host write to a full transmit queue is dropped and the stored entries are unchanged.
- R5: At DEPTH entries the receive-full status bit is set. An engine push into a full receive queue is dropped.
- R6: A host read of an empty receive queue, or an engine pop of an empty transmit queue, has no effect. The queue stays empty and the next accepted entry is the first one delivered.
- R7: The receive-level cause (`cause_lvl[2]`) is high exactly when the receive count is at least `rx_level_sel` + 1.
- R8: The transmit-half-empty cause (`cause_lvl[1]`) is high exactly when the transmit count is DEPTH/2 (8) or less.
- R9: The transmit-empty cause (`cause_lvl[0]`) is high exactly when the transmit queue holds no entries.
- R10: While `tx_flush` is high, the transmit queue is empty from the next cycle on and host writes and engine pops are ignored. The receive queue is not affected.
- R11: Each `cause_pulse[i]` is high for exactly one cycle, in the first cycle in which `cause_lvl[i]` is high after being low. It is never high while its level is low.
- R12: The status nibble `sts_hi` maps to status-register bits 7..4 as follows: [3] transmit empty, [2] receive empty, [1] receive full, [0] transmit full.
- R13: When an entry is accepted into a queue and one is removed from it in the same cycle, and the queue is neither empty nor full, its occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_flush | input | 1 | Holds the transmit queue empty while high |
| host_wr | input | 1 | Host write strobe into the transmit queue |
| host_wr_data | input | TXW (10) | Transmit word: byte plus two control flags |
| host_rd | input | 1 | Host read strobe; pops one receive byte |
| host_rd_data | output | RXW (8) | Receive queue head |
| rx_level_sel | input | AW (4) | Zero-based receive threshold |
| eng_pop | input | 1 | Engine pop from the transmit queue |
| eng_tx_valid | output | 1 | Transmit queue not empty |
| eng_tx_data | output | TXW (10) | Transmit queue head |
| eng_push | input | 1 | Engine push into the receive queue |
| eng_rx_data | input | RXW (8) | Received byte |
| tx_occ | output | AW (4) | Transmit occupancy, zero-based |
| rx_occ | output | AW (4) | Receive occupancy, zero-based |
| sts_hi | output | 4 | Status bits 7..4 |
| cause_lvl | output | 3 | Cause levels: [0] tx empty, [1] tx half, [2] rx level |
| cause_pulse | output | 3 | Single-cycle rise pulse per cause |

## Verification
A corrupted entry count or pointer shows at the ports in the cycle after the edge that corrupts it. The zero-based occupancy, the status nibble and the head word all follow directly from that state, so the check on the next sample disagrees with the reference queues. A lost or duplicated entry moves the head word out of step with the model and is seen at the next pop. A wrong edge register shows up as a missing, doubled or stray cause pulse in the first cycle after the level changes.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

    localparam int FIFO_DEPTH = 16;
    localparam int TX_WORD_W  = 10;
    localparam int RX_WORD_W  = 8;

    localparam int NCAUSE     = 3;
    localparam int CAUSE_TXE  = 0;
    localparam int CAUSE_TXH  = 1;
    localparam int CAUSE_RXL  = 2;
    // levels that hold out of reset (tx empty and half empty high)
    localparam logic [NCAUSE-1:0] CAUSE_RST = 3'b011;

    // field order matches status-register bits 7..4
    typedef struct packed {
        logic tx_empty;
        logic rx_empty;
        logic rx_full;
        logic tx_full;
    } sbf_sts_t;

    // zero-based occupancy; an empty queue also reads zero
    function automatic int zb_occ(input int cnt);
        return (cnt == 0) ? 0 : cnt - 1;
    endfunction

endpackage

// File: rtl/sbf_ring.sv
module sbf_ring #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          do_push;
    logic          do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= wr_ptr + AW'(1);
            end
            if (do_pop) begin
                rd_ptr <= rd_ptr + AW'(1);
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/sbf_cause.sv
module sbf_cause #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1,
    localparam int HALF = DEPTH / 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [CW-1:0]             tx_cnt,
    input  logic [CW-1:0]             rx_cnt,
    input  logic [AW-1:0]             rx_thr,
    output logic [sbf_pkg::NCAUSE-1:0] lvl,
    output logic [sbf_pkg::NCAUSE-1:0] pulse
);

    logic [sbf_pkg::NCAUSE-1:0] prev;
    logic [CW-1:0]              rx_mark;

    assign rx_mark = {1'b0, rx_thr} + CW'(1);

    always_comb begin
        lvl                     = '0;
        lvl[sbf_pkg::CAUSE_TXE] = (tx_cnt == '0);
        lvl[sbf_pkg::CAUSE_TXH] = (tx_cnt <= CW'(HALF));
        lvl[sbf_pkg::CAUSE_RXL] = (rx_cnt >= rx_mark);
    end

    for (genvar i = 0; i < sbf_pkg::NCAUSE; i++) begin : g_edge
        always_ff @(posedge clk) begin
            if (rst) begin
                prev[i] <= sbf_pkg::CAUSE_RST[i];
            end else begin
                prev[i] <= lvl[i];
            end
        end
        assign pulse[i] = lvl[i] & ~prev[i];
    end

endmodule

// File: rtl/sbus_byte_fifos.sv
module sbus_byte_fifos #(
    parameter int DEPTH = sbf_pkg::FIFO_DEPTH,
    parameter int TXW   = sbf_pkg::TX_WORD_W,
    parameter int RXW   = sbf_pkg::RX_WORD_W,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tx_flush,
    input  logic           host_wr,
    input  logic [TXW-1:0] host_wr_data,
    input  logic           host_rd,
    output logic [RXW-1:0] host_rd_data,
    input  logic [AW-1:0]  rx_level_sel,
    input  logic           eng_pop,
    output logic           eng_tx_valid,
    output logic [TXW-1:0] eng_tx_data,
    input  logic           eng_push,
    input  logic [RXW-1:0] eng_rx_data,
    output logic [AW-1:0]  tx_occ,
    output logic [AW-1:0]  rx_occ,
    output logic [3:0]     sts_hi,
    output logic [2:0]     cause_lvl,
    output logic [2:0]     cause_pulse
);

    logic [CW-1:0]      tx_cnt;
    logic [CW-1:0]      rx_cnt;
    logic               tx_full;
    logic               tx_empty;
    logic               rx_full;
    logic               rx_empty;
    sbf_pkg::sbf_sts_t  sts;

    sbf_ring #(.DEPTH(DEPTH), .W(TXW)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .flush     (tx_flush),
        .push      (host_wr),
        .push_data (host_wr_data),
        .pop       (eng_pop),
        .head      (eng_tx_data),
        .count     (tx_cnt),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    sbf_ring #(.DEPTH(DEPTH), .W(RXW)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .flush     (1'b0),
        .push      (eng_push),
        .push_data (eng_rx_data),
        .pop       (host_rd),
        .head      (host_rd_data),
        .count     (rx_cnt),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    sbf_cause #(.DEPTH(DEPTH)) u_cause (
        .clk    (clk),
        .rst    (rst),
        .tx_cnt (tx_cnt),
        .rx_cnt (rx_cnt),
        .rx_thr (rx_level_sel),
        .lvl    (cause_lvl),
        .pulse  (cause_pulse)
    );

    always_comb begin
        sts.tx_empty = tx_empty;
        sts.rx_empty = rx_empty;
        sts.rx_full  = rx_full;
        sts.tx_full  = tx_full;
    end

    assign sts_hi       = sts;
    assign eng_tx_valid = !tx_empty;
    assign tx_occ       = AW'(sbf_pkg::zb_occ(int'(tx_cnt)));
    assign rx_occ       = AW'(sbf_pkg::zb_occ(int'(rx_cnt)));

endmodule

// File: rtl/sbf_chk.sv
module sbf_chk #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst,
    input logic          tx_flush,
    input logic          host_wr,
    input logic          host_rd,
    input logic          eng_pop,
    input logic          eng_push,
    input logic [AW-1:0] tx_occ,
    input logic [AW-1:0] rx_occ,
    input logic [3:0]    sts_hi,
    input logic [2:0]    cause_lvl,
    input logic [2:0]    cause_pulse
);

    assert_occ_empty_R3: assert property (@(posedge clk) disable iff (rst)
        (sts_hi[3] |-> tx_occ == '0) and (sts_hi[2] |-> rx_occ == '0));

    assert_tx_full_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (sts_hi[0] && host_wr && !eng_pop && !tx_flush) |=> sts_hi[0]);

    assert_rx_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (sts_hi[1] && eng_push && !host_rd) |=> (sts_hi[1] && rx_occ == AW'(DEPTH - 1)));

    assert_rx_empty_read_R6: assert property (@(posedge clk) disable iff (rst)
        (sts_hi[2] && host_rd && !eng_push) |=> sts_hi[2]);

    assert_rx_level_R7: assert property (@(posedge clk) disable iff (rst)
        sts_hi[2] |-> !cause_lvl[2]);

    assert_half_cover_R8: assert property (@(posedge clk) disable iff (rst)
        cause_lvl[0] |-> cause_lvl[1]);

    assert_txe_match_R9: assert property (@(posedge clk) disable iff (rst)
        cause_lvl[0] == sts_hi[3]);

    assert_flush_empty_R10: assert property (@(posedge clk) disable iff (rst)
        tx_flush |=> (sts_hi[3] && tx_occ == '0));

    for (genvar i = 0; i < 3; i++) begin : g_pulse
        assert_pulse_lvl_R11: assert property (@(posedge clk) disable iff (rst)
            cause_pulse[i] |-> cause_lvl[i]);
        assert_pulse_once_R11: assert property (@(posedge clk) disable iff (rst)
            cause_pulse[i] |=> !cause_pulse[i]);
    end

    assert_sts_excl_R12: assert property (@(posedge clk) disable iff (rst)
        !(sts_hi[0] && sts_hi[3]) && !(sts_hi[1] && sts_hi[2]));

    assert_balance_R13: assert property (@(posedge clk) disable iff (rst)
        (!sts_hi[3] && !sts_hi[0] && host_wr && eng_pop && !tx_flush) |=> $stable(tx_occ));

endmodule

bind sbus_byte_fifos sbf_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_flush    (tx_flush),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .eng_pop     (eng_pop),
    .eng_push    (eng_push),
    .tx_occ      (tx_occ),
    .rx_occ      (rx_occ),
    .sts_hi      (sts_hi),
    .cause_lvl   (cause_lvl),
    .cause_pulse (cause_pulse)
);

// File: tb/tb_sbus_byte_fifos.sv
module tb_sbus_byte_fifos;

    localparam int D = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_flush = 1'b0;
    logic       host_wr = 1'b0;
    logic [9:0] host_wr_data = '0;
    logic       host_rd = 1'b0;
    logic [7:0] host_rd_data;
    logic [3:0] rx_level_sel = 4'd15;
    logic       eng_pop = 1'b0;
    logic       eng_tx_valid;
    logic [9:0] eng_tx_data;
    logic       eng_push = 1'b0;
    logic [7:0] eng_rx_data = '0;
    logic [3:0] tx_occ;
    logic [3:0] rx_occ;
    logic [3:0] sts_hi;
    logic [2:0] cause_lvl;
    logic [2:0] cause_pulse;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [9:0] txq[$];
    logic [7:0] rxq[$];

    always #10 clk = ~clk;

    sbus_byte_fifos dut (
        .clk(clk), .rst(rst), .tx_flush(tx_flush),
        .host_wr(host_wr), .host_wr_data(host_wr_data),
        .host_rd(host_rd), .host_rd_data(host_rd_data),
        .rx_level_sel(rx_level_sel),
        .eng_pop(eng_pop), .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data),
        .eng_push(eng_push), .eng_rx_data(eng_rx_data),
        .tx_occ(tx_occ), .rx_occ(rx_occ), .sts_hi(sts_hi),
        .cause_lvl(cause_lvl), .cause_pulse(cause_pulse)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_lvl(input int txn, input int rxn, input int th);
        return {rxn >= th + 1, txn <= D / 2, txn == 0};
    endfunction

    function automatic logic [3:0] exp_occ(input int n);
        return (n == 0) ? 4'd0 : 4'(n - 1);
    endfunction

    function automatic logic [3:0] exp_sts(input int txn, input int rxn);
        return {txn == 0, rxn == 0, rxn == D, txn == D};
    endfunction

    // one clock: drive at the falling edge, update the model, sample after the rising edge
    task automatic step(input bit wr, input logic [9:0] wd, input bit rd, input bit pp,
                        input bit ps, input logic [7:0] pd, input bit fl, input logic [3:0] th);
        logic [2:0] prev;
        logic [2:0] lv;
        int ntx;
        int nrx;
        @(negedge clk);
        host_wr = wr; host_wr_data = wd; host_rd = rd; eng_pop = pp;
        eng_push = ps; eng_rx_data = pd; tx_flush = fl; rx_level_sel = th;
        prev = exp_lvl(txq.size(), rxq.size(), int'(th));
        ntx = txq.size();
        nrx = rxq.size();
        if (fl) begin
            txq.delete();
        end else begin
            if (pp && ntx > 0) void'(txq.pop_front());
            if (wr && ntx < D) txq.push_back(wd);
        end
        if (rd && nrx > 0) void'(rxq.pop_front());
        if (ps && nrx < D) rxq.push_back(pd);
        @(posedge clk);
        #1;
        lv = exp_lvl(txq.size(), rxq.size(), int'(th));
        check("R3", "tx_occ", 32'(tx_occ), 32'(exp_occ(txq.size())));
        check("R3", "rx_occ", 32'(rx_occ), 32'(exp_occ(rxq.size())));
        check("R12", "sts_hi", 32'(sts_hi), 32'(exp_sts(txq.size(), rxq.size())));
        check("R9", "txe_lvl", 32'(cause_lvl[0]), 32'(lv[0]));
        check("R8", "txh_lvl", 32'(cause_lvl[1]), 32'(lv[1]));
        check("R7", "rxl_lvl", 32'(cause_lvl[2]), 32'(lv[2]));
        check("R11", "pulse", 32'(cause_pulse), 32'(lv & ~prev));
        check("R2", "tx_valid", 32'(eng_tx_valid), 32'(txq.size() != 0));
        if (txq.size() != 0) check("R2", "tx_head", 32'(eng_tx_data), 32'(txq[0]));
        if (rxq.size() != 0) check("R2", "rx_head", 32'(host_rd_data), 32'(rxq[0]));
    endtask

    task automatic idle(input logic [3:0] th);
        step(0, '0, 0, 0, 0, '0, 0, th);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check("R1", "tx_occ", 32'(tx_occ), 0);
        check("R1", "rx_occ", 32'(rx_occ), 0);
        check("R1", "sts_hi", 32'(sts_hi), 32'hC);
        check("R1", "lvl", 32'(cause_lvl), 32'h3);
        check("R1", "pulse", 32'(cause_pulse), 0);

        // R2: ordering through both queues
        for (int i = 0; i < 5; i++) step(1, 10'(16 * i + 3), 0, 0, 1, 8'(200 - i), 0, 4'd15);
        for (int i = 0; i < 5; i++) step(0, '0, 1, 1, 0, '0, 0, 4'd15);

        // R4: seventeen writes, last dropped, contents intact
        for (int i = 0; i < 17; i++) step(1, 10'(i + 512), 0, 0, 0, '0, 0, 4'd15);
        check("R4", "tx_occ_full", 32'(tx_occ), 15);
        check("R4", "tx_full_bit", 32'(sts_hi[0]), 1);
        for (int i = 0; i < 16; i++) begin
            check("R4", "drain", 32'(eng_tx_data), 32'(i + 512));
            step(0, '0, 0, 1, 0, '0, 0, 4'd15);
        end
        check("R4", "drained", 32'(eng_tx_valid), 0);

        // R5: seventeen pushes into receive queue
        for (int i = 0; i < 17; i++) step(0, '0, 0, 0, 1, 8'(i + 40), 0, 4'd15);
        check("R5", "rx_full_bit", 32'(sts_hi[1]), 1);
        check("R5", "rx_occ_full", 32'(rx_occ), 15);
        for (int i = 0; i < 16; i++) begin
            check("R5", "drain", 32'(host_rd_data), 32'(i + 40));
            step(0, '0, 1, 0, 0, '0, 0, 4'd15);
        end

        // R6: reads and pops on empty queues
        for (int i = 0; i < 3; i++) step(0, '0, 1, 1, 0, '0, 0, 4'd15);
        check("R6", "rx_empty", 32'(sts_hi[2]), 1);
        check("R6", "tx_empty", 32'(sts_hi[3]), 1);
        step(1, 10'h2A5, 0, 0, 1, 8'h5C, 0, 4'd15);
        check("R6", "rx_first", 32'(host_rd_data), 32'h5C);
        check("R6", "tx_first", 32'(eng_tx_data), 32'h2A5);
        step(0, '0, 1, 1, 0, '0, 0, 4'd15);

        // R7: threshold 3 needs four entries
        idle(4'd3);
        for (int i = 0; i < 3; i++) step(0, '0, 0, 0, 1, 8'(i), 0, 4'd3);
        check("R7", "below", 32'(cause_lvl[2]), 0);
        step(0, '0, 0, 0, 1, 8'h77, 0, 4'd3);
        check("R7", "at_mark", 32'(cause_lvl[2]), 1);
        check("R11", "rx_rise", 32'(cause_pulse[2]), 1);
        idle(4'd3);
        check("R11", "rx_once", 32'(cause_pulse[2]), 0);
        for (int i = 0; i < 4; i++) step(0, '0, 1, 0, 0, '0, 0, 4'd3);

        // R13: balanced traffic
        for (int i = 0; i < 4; i++) step(1, 10'(i + 100), 0, 0, 1, 8'(i), 0, 4'd15);
        for (int i = 0; i < 5; i++) step(1, 10'(i + 300), 1, 1, 1, 8'(i + 9), 0, 4'd15);
        check("R13", "tx_occ", 32'(tx_occ), 3);
        check("R13", "rx_occ", 32'(rx_occ), 3);

        // R10: flush empties tx only and blocks writes
        for (int i = 0; i < 3; i++) step(1, 10'(i + 700), 0, 0, 0, '0, 0, 4'd15);
        for (int i = 0; i < 3; i++) step(1, 10'h3FF, 0, 1, 0, '0, 1, 4'd15);
        check("R10", "tx_flushed", 32'(sts_hi[3]), 1);
        check("R10", "rx_kept", 32'(rx_occ), 3);
        step(1, 10'h155, 0, 0, 0, '0, 0, 4'd15);
        check("R10", "after", 32'(eng_tx_data), 32'h155);
        check("R10", "after_occ", 32'(tx_occ), 0);

        // random traffic with shifting bias
        for (int blk = 0; blk < 20; blk++) begin
            int wbias = (blk % 2 == 0) ? 3 : 1;
            logic [3:0] th = 4'($urandom % 16);
            for (int i = 0; i < 150; i++) begin
                bit wr = ($urandom % 4) < wbias;
                bit pp = ($urandom % 4) < (4 - wbias);
                bit ps = ($urandom % 4) < wbias;
                bit rd = ($urandom % 4) < (4 - wbias);
                bit fl = ($urandom % 60) == 0;
                if (($urandom % 25) == 0) th = 4'($urandom % 16);
                step(wr, 10'($urandom), rd, pp, ps, 8'($urandom), fl, th);
            end
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule